// File: doc/BRIEF.md
# Programmable Waveform Sequencer Engine

This block runs small microprograms that pace a parallel sampling interface. A 128-byte waveform store, loaded one byte at a time through a configuration port, holds four waveforms. Each waveform describes seven programmable steps (states 0 to 6), and state 7 is the idle state. A step either waits for a programmed number of clocks or makes a one-clock decision. A decision branches on a logic function of two selectable status terms, one of which is the FIFO-full flag. While a step is active, its opcode can request that the data bus be captured, and its output byte drives the control lines.

A transaction is started with a 2-bit type code. A select register maps each type to one of the four waveforms, and the engine then runs from state 0 until it reaches idle or is aborted. While idle, the control lines show a programmable idle value and no sample strobe is produced. Configuration address 0 to 127 is the waveform store, laid out as waveform*32 + plane*8 + state. The planes, in order, are length/branch, opcode, output and logic function. Address 128 is the select register and address 129 is the idle control value.

Top module: `wfseq_engine`

## Requirements
- R1: After reset the engine is idle: stateNum is 7, busy is 0, done is 0, sampleStrobe is 0, and ctlOut is 0, because the idle control value resets to 0.
- R2: The select register (config address 128) picks the waveform for each start type using 2-bit fields: bits 1:0 for type 0 (FIFO read), bits 3:2 for type 1 (FIFO write), bits 5:4 for type 2 (single read) and bits 7:6 for type 3 (single write). A start accepted while idle enters state 0 of the selected waveform at the next clock edge.
- R3: A step whose opcode bit 0 is 0 stays active for the number of clocks in its length/branch byte, then moves to the next state. A length of 0 means 256 clocks.
- R4: A step whose opcode bit 0 is 1 lasts one clock. It then goes to the state in length/branch bits 5:3 if the logic result is 1, and otherwise to the state in bits 2:0.
- R5: The logic function byte is decoded as follows. Bits 7:6 select the operator: 0 is A AND B, 1 is A OR B, 2 is A XOR B, 3 is (NOT A) AND B. Bits 5:3 select term A and bits 2:0 select term B. Term code 6 is fifoFull, code 7 is constant 1, and every other code reads 0. With 0x36, a full FIFO takes the "1" branch.
- R6: sampleStrobe is 1 exactly while a running step has opcode bit 1 set, and sampleData then carries busIn. sampleStrobe is never 1 in idle.
- R7: While running, ctlOut carries bits 5:0 of the current step's output byte. While idle, it carries the idle control value written at config address 129.
- R8: Reaching state 7 ends the waveform. busy falls and done is set. done is cleared when a new start is accepted.
- R9: When the selected branch target of a decision step is 7 and length/branch bit 7 (re-execute) is set, the engine goes to state 0 instead of idle, and done stays 0.
- R10: abortReq forces state 7 at the next edge and sets done if the engine was running. It takes priority over a start in the same cycle.
- R11: A start request while the engine is running is ignored: the running waveform continues.
- R12: A waiting step in state 6 that completes its count leads to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration byte write strobe |
| cfgAddr | input | 8 | Configuration address (0-127 store, 128 select, 129 idle control) |
| cfgData | input | 8 | Configuration write data |
| startReq | input | 1 | Start a transaction (accepted only when idle) |
| startType | input | 2 | Transaction type code |
| abortReq | input | 1 | Force the engine to idle |
| fifoFull | input | 1 | FIFO full flag used as a logic term |
| busIn | input | DATA_W | Parallel data bus being sampled |
| sampleStrobe | output | 1 | Write strobe toward the FIFO |
| sampleData | output | DATA_W | Data presented with sampleStrobe |
| ctlOut | output | CTL_W | Control outputs |
| stateNum | output | 3 | Current state, 7 = idle |
| busy | output | 1 | Engine running a waveform |
| done | output | 1 | Waveform finished or aborted |

## Verification
The assertions assume that fifoFull and busIn are settled during each clock, because a decision reads them in the cycle it is active. They also assume that configuration writes do not rewrite the active waveform while it is running. The stimulus changes every input only at the falling edge. It loads and modifies the store only while the engine is idle, and before each new program it returns the engine to idle with an abort.

// File: rtl/wfseq_pkg.sv
package wfseq_pkg;
  localparam int NUM_WF    = 4;
  localparam int NUM_PLANE = 4;
  localparam int NUM_SLOT  = 8;
  localparam int MEM_DEPTH = NUM_WF * NUM_PLANE * NUM_SLOT;
  localparam int MEM_AW    = $clog2(MEM_DEPTH);
  localparam int ST_W      = $clog2(NUM_SLOT);
  localparam int WF_W      = $clog2(NUM_WF);
  localparam logic [ST_W-1:0] IDLE_ST = ST_W'(NUM_SLOT - 1);

  typedef enum logic [1:0] {PL_LENBR = 2'd0, PL_OPCODE = 2'd1,
                            PL_OUTPUT = 2'd2, PL_LFUNC = 2'd3} plane_e;

  // control -> datapath
  typedef struct packed {
    logic            running;
    logic [ST_W-1:0] state;
    logic [WF_W-1:0] wfIdx;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic            isDecision;
    logic [7:0]      length;
    logic [ST_W-1:0] target;
    logic            reExec;
  } stepInfo_t;
endpackage

// File: rtl/wfseq_datapath.sv
module wfseq_datapath
  import wfseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic [1:0]        startType,
  input  logic              fifoFull,
  input  logic [DATA_W-1:0] busIn,
  input  seqStrobe_t        strb,
  output logic [WF_W-1:0]   selWf,
  output stepInfo_t         info,
  output logic              sampleStrobe,
  output logic [DATA_W-1:0] sampleData,
  output logic [CTL_W-1:0]  ctlOut
);
  localparam logic [7:0] SEL_ADDR  = 8'(MEM_DEPTH);
  localparam logic [7:0] IDLE_ADDR = 8'(MEM_DEPTH + 1);

  logic [7:0]       wfMem [MEM_DEPTH];
  logic [7:0]       selReg;
  logic [CTL_W-1:0] idleCtl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) wfMem[i] <= 8'h00;
      selReg  <= 8'h00;
      idleCtl <= '0;
    end else if (cfgWe) begin
      if (cfgAddr < SEL_ADDR) wfMem[cfgAddr[MEM_AW-1:0]] <= cfgData;
      else if (cfgAddr == SEL_ADDR) selReg <= cfgData;
      else if (cfgAddr == IDLE_ADDR) idleCtl <= cfgData[CTL_W-1:0];
    end
  end

  assign selWf = selReg[{startType, 1'b0} +: WF_W];

  // fetch the four plane bytes of the active step
  logic [7:0] planeByte [NUM_PLANE];
  for (genvar p = 0; p < NUM_PLANE; p++) begin : g_plane
    assign planeByte[p] = wfMem[{strb.wfIdx, 2'(p), strb.state}];
  end

  logic [7:0] lenBr, opByte, outByte, lfByte;
  assign lenBr   = planeByte[PL_LENBR];
  assign opByte  = planeByte[PL_OPCODE];
  assign outByte = planeByte[PL_OUTPUT];
  assign lfByte  = planeByte[PL_LFUNC];

  function automatic logic termVal(input logic [2:0] code, input logic full);
    case (code)
      3'd6:    termVal = full;
      3'd7:    termVal = 1'b1;
      default: termVal = 1'b0;
    endcase
  endfunction

  logic termA, termB, lfResult;
  always_comb begin
    termA = termVal(lfByte[5:3], fifoFull);
    termB = termVal(lfByte[2:0], fifoFull);
    case (lfByte[7:6])
      2'd0:    lfResult = termA & termB;
      2'd1:    lfResult = termA | termB;
      2'd2:    lfResult = termA ^ termB;
      default: lfResult = ~termA & termB;
    endcase
  end

  always_comb begin
    info.isDecision = opByte[0];
    info.length     = lenBr;
    info.target     = lfResult ? lenBr[5:3] : lenBr[2:0];
    info.reExec     = lenBr[7];
  end

  assign sampleStrobe = strb.running & opByte[1];
  assign sampleData   = busIn;
  assign ctlOut       = strb.running ? outByte[CTL_W-1:0] : idleCtl;
endmodule

// File: rtl/wfseq_ctrl.sv
module wfseq_ctrl
  import wfseq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            abortReq,
  input  logic [WF_W-1:0] selWf,
  input  stepInfo_t       info,
  output seqStrobe_t      strb,
  output logic            done
);
  logic [ST_W-1:0] curState, nextState;
  logic [WF_W-1:0] wfIdx;
  logic [7:0]      holdCnt;
  logic            running, stepEnd;

  assign running = (curState != IDLE_ST);
  assign stepEnd = info.isDecision || (holdCnt == info.length - 8'd1);

  always_comb begin
    nextState = curState;
    if (info.isDecision)
      nextState = (info.target == IDLE_ST && info.reExec) ? '0 : info.target;
    else if (stepEnd)
      nextState = curState + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= IDLE_ST;
      wfIdx    <= '0;
      holdCnt  <= '0;
      done     <= 1'b0;
    end else if (abortReq) begin
      if (running) begin
        curState <= IDLE_ST;
        done     <= 1'b1;
      end
      holdCnt <= '0;
    end else if (!running) begin
      if (startReq) begin
        curState <= '0;
        wfIdx    <= selWf;
        holdCnt  <= '0;
        done     <= 1'b0;
      end
    end else begin
      curState <= nextState;
      holdCnt  <= stepEnd ? 8'd0 : holdCnt + 8'd1;
      if (nextState == IDLE_ST) done <= 1'b1;
    end
  end

  assign strb = '{running: running, state: curState, wfIdx: wfIdx};

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> curState == IDLE_ST); // R10
  AST_START_STATE0: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startReq && !abortReq) |=> curState == '0 && !done); // R2
  AST_DONE_ON_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (running && !abortReq && nextState == IDLE_ST) |=> done && !running); // R8
  AST_REEXEC_NOIDLE: assert property (@(posedge clk) disable iff (!rstN)
    (running && info.isDecision && info.reExec && !abortReq) |=> curState != IDLE_ST); // R9
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (running && !info.isDecision && info.length != 8'd0) |-> holdCnt < info.length); // R3
endmodule

// File: rtl/wfseq_engine.sv
module wfseq_engine
  import wfseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [7:0]        cfgAddr,
  input  logic [7:0]        cfgData,
  input  logic              startReq,
  input  logic [1:0]        startType,
  input  logic              abortReq,
  input  logic              fifoFull,
  input  logic [DATA_W-1:0] busIn,
  output logic              sampleStrobe,
  output logic [DATA_W-1:0] sampleData,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [2:0]        stateNum,
  output logic              busy,
  output logic              done
);
  seqStrobe_t      strb;
  stepInfo_t       info;
  logic [WF_W-1:0] selWf;

  wfseq_datapath #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .startType(startType), .fifoFull(fifoFull), .busIn(busIn), .strb(strb),
    .selWf(selWf), .info(info), .sampleStrobe(sampleStrobe),
    .sampleData(sampleData), .ctlOut(ctlOut)
  );

  wfseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .selWf(selWf), .info(info), .strb(strb), .done(done)
  );

  assign stateNum = strb.state;
  assign busy     = strb.running;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (stateNum == 3'd7) |-> !sampleStrobe); // R6
endmodule

// File: tb/wfseq_engine_tb.sv
`timescale 1ns/100ps
module wfseq_engine_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgAddr = '0, cfgData = '0;
  logic       startReq = 1'b0;
  logic [1:0] startType = '0;
  logic       abortReq = 1'b0;
  logic       fifoFull = 1'b0;
  logic [7:0] busIn = '0;
  logic       sampleStrobe;
  logic [7:0] sampleData;
  logic [5:0] ctlOut;
  logic [2:0] stateNum;
  logic       busy, done;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wfseq_engine u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .startReq(startReq), .startType(startType), .abortReq(abortReq),
    .fifoFull(fifoFull), .busIn(busIn), .sampleStrobe(sampleStrobe),
    .sampleData(sampleData), .ctlOut(ctlOut), .stateNum(stateNum),
    .busy(busy), .done(done)
  );

  // {logic byte, fifoFull, expected state}; "1" target = 1, "0" target = 2
  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {8'h36, 1'b1, 3'd1}, {8'h36, 1'b0, 3'd2}, {8'h76, 1'b0, 3'd2},
    {8'h7E, 1'b0, 3'd1}, {8'hB7, 1'b1, 3'd2}, {8'hB7, 1'b0, 3'd1},
    {8'hF7, 1'b0, 3'd1}, {8'hF7, 1'b1, 3'd2}, {8'h06, 1'b1, 3'd2},
    {8'h3F, 1'b0, 3'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input int addr, input int data);
    cfgWe = 1'b1; cfgAddr = 8'(addr); cfgData = 8'(data);
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic prog(input int wf, input int st, input int lb, input int op,
                      input int outv, input int lf);
    wr(wf*32 + 0 + st, lb);
    wr(wf*32 + 8 + st, op);
    wr(wf*32 + 16 + st, outv);
    wr(wf*32 + 24 + st, lf);
  endtask

  // returns at the first falling edge inside state 0
  task automatic startRun(input int t);
    startReq = 1'b1; startType = 2'(t);
    tick();
    startReq = 1'b0;
  endtask

  task automatic abortRun();
    abortReq = 1'b1;
    tick();
    abortReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check("R1 state", stateNum, 7);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 strobe", sampleStrobe, 0);
    check("R1 ctl", ctlOut, 0);

    // waveform 0: decision at state 0, NDP at 1 and 2
    prog(0, 0, 8'h0A, 8'h01, 8'h00, 8'h36);
    prog(0, 1, 8'h01, 8'h00, 8'h11, 8'h00);
    prog(0, 2, 8'h01, 8'h00, 8'h22, 8'h00);
    prog(0, 6, 8'h01, 8'h00, 8'h00, 8'h00);

    // R4 / R5 logic function table
    for (int v = 0; v < NV; v++) begin
      wr(24, VEC[v][11:4]);
      fifoFull = VEC[v][3];
      startRun(0);
      check("R2 enter state0", stateNum, 0);
      tick();
      check("R5 branch target", stateNum, VEC[v][2:0]);
      abortRun();
    end

    // R10 abort result
    check("R10 abort idle", stateNum, 7);
    check("R10 abort done", done, 1);

    // R2 / R3 / R7: waveform 1 waits 3 clocks, type 1 maps via bits 3:2
    prog(1, 0, 8'h03, 8'h00, 8'h05, 8'h00);
    prog(2, 0, 8'h02, 8'h02, 8'h15, 8'h00);
    wr(128, 8'h24);
    startRun(1);
    check("R8 done cleared", done, 0);
    check("R7 ctl from output plane", ctlOut, 5);
    check("R3 cycle1", stateNum, 0);
    // R11 start while running is ignored
    startReq = 1'b1; startType = 2'd2;
    tick();
    startReq = 1'b0;
    check("R11 ignored start ctl", ctlOut, 5);
    check("R3 cycle2", stateNum, 0);
    tick();
    check("R3 cycle3", stateNum, 0);
    tick();
    check("R3 advance after 3", stateNum, 1);
    abortRun();

    // R3 length 0 means 256 clocks
    wr(32, 8'h00);
    startRun(1);
    for (int c = 2; c <= 256; c++) tick();
    check("R3 len0 still at 256", stateNum, 0);
    tick();
    check("R3 len0 advance at 257", stateNum, 1);
    abortRun();

    // R6 sampling, type 2 -> waveform 2
    busIn = 8'hA5;
    startRun(2);
    check("R6 strobe", sampleStrobe, 1);
    check("R6 data", sampleData, 8'hA5);
    check("R2 type2 waveform ctl", ctlOut, 8'h15);
    abortRun();
    check("R6 idle strobe", sampleStrobe, 0);

    // R7 idle control value
    wr(129, 8'h2A);
    check("R7 idle ctl", ctlOut, 8'h2A);

    // R10 abort beats start
    abortReq = 1'b1; startReq = 1'b1; startType = 2'd0;
    tick();
    abortReq = 1'b0; startReq = 1'b0;
    check("R10 abort priority", stateNum, 7);
    check("R10 idle ctl kept", ctlOut, 8'h2A);

    // R12 / R8: decision to state 6, then idle
    wr(0, 8'h06); wr(24, 8'h36); fifoFull = 1'b0;
    startRun(0);
    check("R8 done low while running", done, 0);
    tick();
    check("R12 at state 6", stateNum, 6);
    tick();
    check("R12 reached idle", stateNum, 7);
    check("R8 done set", done, 1);
    check("R8 busy low", busy, 0);

    // R9 re-execute on idle target
    wr(0, 8'hB9); fifoFull = 1'b1;
    startRun(0);
    tick();
    check("R9 restart state0", stateNum, 0);
    check("R9 done low", done, 0);
    abortRun();

    // R4 / R8 decision into idle without re-execute
    wr(0, 8'h39);
    startRun(0);
    tick();
    check("R4 branch to idle", stateNum, 7);
    check("R8 done after branch", done, 1);

    finishRun();
  end
endmodule